// File: doc/BRIEF.md
# Detection Map Byte Streamer

The streamer walks a packed detection memory and turns its used part into a byte stream with valid/ready handshaking, for the framer that builds host transfers. The memory has one word per byte slot, 16 slots per range bin, and only the first 12 slots of each range hold data (Doppler bins 0..47, four bins per byte). The streamer sends those 12 bytes for each of the 512 ranges, 6144 bytes in all, and skips the four spare slots of every range.

The memory read port is synchronous with one cycle of latency. While idle, the streamer keeps address 0 on the port, so word 0 is already settled when a section starts. On entry, the lookahead address and the per-range slot index are loaded one step ahead, to slot 1. The first byte on the stream is word 0, and from then on a new byte can leave on every cycle. A section can be started from any of several request inputs, and every one of them applies the same preload. When the downstream stalls, the address presented to the memory falls back to the byte on display, so the output holds its value. After the last byte is accepted, a one-cycle done pulse is raised.

Top module: `detmap_streamer`

## Requirements
- R1: After reset, `out_valid` and `done` are 0. Whenever `out_valid` is 0, `mem_addr` is 0.
- R2: A 1 on any bit of `entry_req` while idle starts a section, and `out_valid` is 1 on the next cycle. Every bit gives the same stream.
- R3: Stream byte k (k = 0..6143) equals the memory word at address (k/12)*16 + (k mod 12). The first byte is word 0, and no byte is shifted by one slot.
- R4: Each range gives exactly 12 bytes. After slot 11 of range r, the next address read is (r+1)*16, and slots 12..15 are never read while streaming.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_data` stays stable and `mem_addr` holds the address of the byte on display, so no byte is lost or repeated.
- R6: With `out_ready` held at 1, `out_valid` stays 1 for 6144 consecutive cycles, with no bubble.
- R7: `done` is 1 for exactly one cycle, in the cycle after the 6144th byte is accepted, and `out_valid` is 0 in that cycle.
- R8: Pulses on `entry_req` while a section is streaming are ignored, and the stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 3 | Section start requests, one per entry path |
| mem_addr | output | 13 | Read address to the detection memory |
| mem_rdata | input | 8 | Read data from the memory, one cycle after the address |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Stream byte |
| done | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
A lookahead register that is off by one shows at once on the first byte as word 1 instead of word 0. If the slip happens later, every byte after it is wrong by four Doppler bins. A slot index that mishandles the range boundary first shows up at byte 12, where a spare slot such as address 12 appears in place of address 16. A stall path that does not hold the address shows up one cycle after the first stall as a skipped byte. A beat counter fault shows up as a missing or misplaced done pulse at the end of the section.

// File: rtl/detmap_pkg.sv
package detmap_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_EMIT = 1'b1
   } emit_state_t;
endpackage

// File: rtl/detmap_entry.sv
// Merges the entry paths into a single start strobe, taken only while idle.
module detmap_entry #(
   parameter int ENTRY_PATHS = 3
) (
   input  logic                   idle_i,
   input  logic [ENTRY_PATHS-1:0] req_i,
   output logic                   start_o
);
   logic any_req;

   generate
      if (ENTRY_PATHS == 1) begin : g_single
         assign any_req = req_i[0];
      end else begin : g_multi
         assign any_req = |req_i;
      end
   endgenerate

   assign start_o = idle_i & any_req;
endmodule

// File: rtl/detmap_addr_seq.sv
// Lookahead read-address sequencer. head_q is the address of the byte on
// display; ahead_q is the address of the byte after it, within range slots.
module detmap_addr_seq #(
   parameter int SLOT_W     = 4,
   parameter int RANGE_W    = 9,
   parameter int USED_BYTES = 12,
   localparam int ADDR_W    = SLOT_W + RANGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              clear_i,
   output logic [ADDR_W-1:0] head_o,
   output logic [ADDR_W-1:0] ahead_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(USED_BYTES - 1);

   logic [ADDR_W-1:0] head_q, ahead_q;
   logic [SLOT_W-1:0] idx_q;
   logic [ADDR_W-1:0] nxt_addr, pre_addr;
   logic [SLOT_W-1:0] nxt_idx, pre_idx;

   // One step from (addr, idx): next slot, or slot 0 of the next range.
   function automatic void step_fn(input  logic [ADDR_W-1:0] a,
                                   input  logic [SLOT_W-1:0] i,
                                   output logic [ADDR_W-1:0] na,
                                   output logic [SLOT_W-1:0] ni);
      if (i == LAST_SLOT) begin
         na = {a[ADDR_W-1:SLOT_W] + RANGE_W'(1), {SLOT_W{1'b0}}};
         ni = '0;
      end else begin
         na = a + ADDR_W'(1);
         ni = i + SLOT_W'(1);
      end
   endfunction

   always_comb begin
      step_fn(ahead_q, idx_q, nxt_addr, nxt_idx);
      step_fn('0, '0, pre_addr, pre_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         ahead_q <= '0;
         idx_q   <= '0;
      end else if (load_i) begin
         head_q  <= '0;
         ahead_q <= pre_addr;
         idx_q   <= pre_idx;
      end else if (clear_i) begin
         head_q  <= '0;
         ahead_q <= '0;
         idx_q   <= '0;
      end else if (step_i) begin
         head_q  <= ahead_q;
         ahead_q <= nxt_addr;
         idx_q   <= nxt_idx;
      end
   end

   assign head_o  = head_q;
   assign ahead_o = ahead_q;
endmodule

// File: rtl/detmap_beat_cnt.sv
// Counts accepted bytes and flags the final one of the section.
module detmap_beat_cnt #(
   parameter int TOTAL = 6144,
   localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic fire_i,
   output logic last_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= '0;
      else if (fire_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign last_o = (cnt_q == CNT_W'(TOTAL - 1));
endmodule

// File: rtl/detmap_streamer.sv
module detmap_streamer #(
   parameter int RANGE_BINS  = 512,
   parameter int SLOT_STRIDE = 16,
   parameter int USED_BYTES  = 12,
   parameter int DATA_W      = 8,
   parameter int ENTRY_PATHS = 3,
   localparam int SLOT_W     = $clog2(SLOT_STRIDE),
   localparam int RANGE_W    = $clog2(RANGE_BINS),
   localparam int ADDR_W     = SLOT_W + RANGE_W,
   localparam int TOTAL      = RANGE_BINS * USED_BYTES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ENTRY_PATHS-1:0] entry_req,
   output logic [ADDR_W-1:0]      mem_addr,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [DATA_W-1:0]      out_data,
   output logic                   done
);
   import detmap_pkg::*;

   generate
      if (SLOT_STRIDE != (1 << SLOT_W)) begin : g_bad_stride
         $error("SLOT_STRIDE must be a power of two");
      end
      if (USED_BYTES < 1 || USED_BYTES > SLOT_STRIDE) begin : g_bad_used
         $error("USED_BYTES must lie in 1..SLOT_STRIDE");
      end
      if (RANGE_BINS < 2 || RANGE_BINS != (1 << RANGE_W)) begin : g_bad_ranges
         $error("RANGE_BINS must be a power of two, at least 2");
      end
   endgenerate

   emit_state_t       state_q;
   logic              start, fire, last_beat, fin;
   logic [ADDR_W-1:0] head_addr, ahead_addr;
   logic              done_q;

   detmap_entry #(.ENTRY_PATHS(ENTRY_PATHS)) u_entry (
      .idle_i  (state_q == ST_IDLE),
      .req_i   (entry_req),
      .start_o (start)
   );

   assign fire = (state_q == ST_EMIT) && out_ready;
   assign fin  = fire && last_beat;

   detmap_addr_seq #(
      .SLOT_W(SLOT_W), .RANGE_W(RANGE_W), .USED_BYTES(USED_BYTES)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (start),
      .step_i  (fire),
      .clear_i (fin),
      .head_o  (head_addr),
      .ahead_o (ahead_addr)
   );

   detmap_beat_cnt #(.TOTAL(TOTAL)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .fire_i (fire),
      .last_o (last_beat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= fin;
         if (start)    state_q <= ST_EMIT;
         else if (fin) state_q <= ST_IDLE;
      end
   end

   // Stalled: re-read the byte on display. Otherwise fetch the lookahead.
   assign mem_addr  = (state_q == ST_EMIT && !out_ready) ? head_addr : ahead_addr;
   assign out_valid = (state_q == ST_EMIT);
   assign out_data  = mem_rdata;
   assign done      = done_q;
endmodule

// File: rtl/detmap_streamer_chk.sv
module detmap_streamer_chk #(
   parameter int SLOT_W      = 4,
   parameter int ADDR_W      = 13,
   parameter int USED_BYTES  = 12,
   parameter int DATA_W      = 8,
   parameter int ENTRY_PATHS = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ENTRY_PATHS-1:0] entry_req,
   input logic [ADDR_W-1:0]      mem_addr,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [DATA_W-1:0]      out_data,
   input logic                   done
);
   AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> mem_addr == '0); // R1
   AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(|entry_req)); // R2
   AST_SLOT_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> {1'b0, mem_addr[SLOT_W-1:0]} < (SLOT_W+1)'(USED_BYTES)); // R4
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid); // R7
endmodule

bind detmap_streamer detmap_streamer_chk #(
   .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .USED_BYTES(USED_BYTES),
   .DATA_W(DATA_W), .ENTRY_PATHS(ENTRY_PATHS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .mem_addr(mem_addr),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/detmap_streamer_tb_top.sv
module detmap_streamer_tb_top;
   localparam int TOTAL = 6144;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  entry_req = '0;
   logic [12:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        out_valid, out_ready, done;
   logic [7:0]  out_data;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   detmap_streamer dut_i (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .done(done)
   );

   function automatic logic [7:0] pat(input logic [12:0] a);
      return 8'(a * 37) ^ 8'(a >> 8) ^ 8'hA5;
   endfunction

   function automatic logic [12:0] addr_of(input int k);
      return 13'((k / 12) * 16 + (k % 12));
   endfunction

   // Memory model: synchronous read, one cycle of latency.
   always_ff @(posedge clk) mem_rdata <= pat(mem_addr);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Run table: [3:2] entry path, [1:0] ready mode
   // (0 always, 1 random half, 2 alternate, 3 random quarter).
   localparam logic [3:0] RUNS [5] = '{4'b00_00, 4'b01_01, 4'b10_10, 4'b00_11, 4'b10_00};

   task automatic stream_run(input int path, input int mode);
      int  k = 0;
      bit  prev_stall = 0;
      logic [7:0] held = '0;
      int  guard = 0;
      bit  bubble = 0;
      entry_req = 3'(1 << path);
      out_ready = 1'b0;
      @(negedge clk);
      entry_req = '0;
      chk(out_valid == 1'b1, "R2", out_valid, 1);
      while (k < TOTAL && guard < 40000) begin
         guard++;
         case (mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'($urandom_range(0, 1));
            2: out_ready = guard[0];
            default: out_ready = ($urandom_range(0, 3) == 0);
         endcase
         entry_req = (k == 100) ? 3'(1 << ((path + 1) % 3)) : 3'b0;  // R8 stimulus
         #1;
         if (!out_valid) bubble = 1;
         if (prev_stall) chk(out_data == held, "R5", out_data, held);
         if (out_valid && !out_ready)
            chk(mem_addr == addr_of(k), "R5", mem_addr, addr_of(k));
         if (out_valid && out_ready) begin
            chk(out_data == pat(addr_of(k)), "R3", out_data, pat(addr_of(k)));
            if (k % 12 == 11 && k != TOTAL - 1)
               chk(mem_addr == addr_of(k + 1), "R4", mem_addr, addr_of(k + 1));
            k++;
         end
         prev_stall = out_valid && !out_ready;
         held = out_data;
         @(negedge clk);
      end
      entry_req = '0;
      out_ready = 1'b0;
      chk(k == TOTAL, "R8", k, TOTAL);
      chk(!bubble, "R6", bubble, 0);
      chk(done == 1'b1 && out_valid == 1'b0, "R7", {done, out_valid}, 2);
      @(negedge clk);
      chk(done == 1'b0, "R7", done, 0);
      chk(mem_addr == '0, "R1", mem_addr, 0);
   endtask

   initial begin
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && done == 1'b0 && mem_addr == '0, "R1",
          {out_valid, done, |mem_addr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && done == 1'b0, "R1", {out_valid, done}, 0);

      foreach (RUNS[i]) stream_run(int'(RUNS[i][3:2]), int'(RUNS[i][1:0]));

      // Directed: start under immediate back-pressure, first byte is word 0 (R3).
      entry_req = 3'b100;
      @(negedge clk);
      entry_req = '0;
      repeat (4) begin
         chk(out_valid && out_data == pat(13'd0), "R3", out_data, pat(13'd0));
         @(negedge clk);
      end
      // Reset mid-section returns to idle (R1).
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && mem_addr == '0, "R1", out_valid, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000 && !finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule